// File: doc/BRIEF.md
# Cyclic-Carry Lookahead Adder Modulo 2^W-1

This block adds two W-bit residues and returns their sum modulo 2^W-1 (with the default W = 8, modulo 255). It is meant to be the final carry-propagate stage of a residue multiplier, where the accumulated carry-save vectors have to be resolved into one residue.

The carry leaving the top bit wraps into bit 0. That end-around carry is not fed back through a second addition. Each bit's carry is written as one flat sum of products over the bit generates and propagates, taken cyclically around the word. The whole wrap is therefore resolved in a single lookahead level.

The adder core is combinational. One output register with synchronous active-high reset sits behind it, so the result appears one clock after the operands are sampled.

Top module: `eac_mod_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` is loaded with all zeros.
- R2: With `rst` low, `sum_o` after a rising edge depends only on `a_i` and `b_i` sampled at that edge, so the latency is exactly one clock.
- R3: The registered result is congruent to a_i + b_i modulo 2^W-1.
- R4: The result is exactly a_i + b_i when that integer sum is at most 2^W-1. Otherwise it is a_i + b_i - (2^W-1). It never needs more than W bits.
- R5: When every bit of a_i XOR b_i is 1, the result is all ones, which is the redundant form of zero. Operands 0 and 0 give all zeros. Operands all-ones and all-ones give all ones.
- R6: A carry out of bit W-1 enters bit 0 in the same pass. For example, 0x80 + 0x80 gives 0x01, and 0xFF + 0x01 gives 0x01.
- R7: The result is unchanged when the two operands are swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_i | input | W | First residue operand |
| b_i | input | W | Second residue operand |
| sum_o | output | W | Registered sum modulo 2^W-1 |

## Verification
Every one of the 65,536 operand pairs is applied and compared bit for bit with the exact end-around rule.

Directed cases cover the following faults:
- Pairs whose propagates are all ones. A design that treats the all-propagate ring as carrying would return zero or a value one too large.
- Pairs where only the top bit generates. A design that drops the wrapped generate terms would lose the carry into bit 0 and give 0x00 in place of 0x01.
- Swapped operands and the reset value. These catch asymmetric carry terms and a register that is not cleared.

// File: rtl/eac_pkg.sv
package eac_pkg;
  localparam int EAC_DEFAULT_W = 8;

  function automatic int ring_idx(input int pos, input int w);
    return ((pos % w) + w) % w;
  endfunction
endpackage

// File: rtl/eac_gp.sv
module eac_gp #(
  parameter int W = eac_pkg::EAC_DEFAULT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/eac_ring_carry.sv
module eac_ring_carry #(
  parameter int W = eac_pkg::EAC_DEFAULT_W
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  output logic [W-1:0] c
);
  // c[i] is the carry leaving bit i. Generates are visited from bit i
  // downward and then around the ring, each gated by the propagates between.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      logic acc;
      logic chain;
      acc   = 1'b0;
      chain = 1'b1;
      for (int d = 0; d < W; d++) begin
        int k;
        k     = eac_pkg::ring_idx(i - d, W);
        acc   = acc | (g[k] & chain);
        chain = chain & p[k];
      end
      c[i] = acc;
    end
  end
endmodule

// File: rtl/eac_sum.sv
module eac_sum #(
  parameter int W = eac_pkg::EAC_DEFAULT_W
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] c,
  output logic [W-1:0] s
);
  for (genvar i = 0; i < W; i++) begin : g_sum
    localparam int PREV = (i + W - 1) % W;
    assign s[i] = p[i] ^ c[PREV];
  end
endmodule

// File: rtl/eac_mod_adder.sv
module eac_mod_adder #(
  parameter int W = eac_pkg::EAC_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int MODV = (1 << W) - 1;

  logic [W-1:0] gen_w, prop_w, carry_w, sum_w, sum_q;

  eac_gp #(.W(W)) u_gp (.a(a_i), .b(b_i), .g(gen_w), .p(prop_w));
  eac_ring_carry #(.W(W)) u_carry (.g(gen_w), .p(prop_w), .c(carry_w));
  eac_sum #(.W(W)) u_sum (.p(prop_w), .c(carry_w), .s(sum_w));

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_w;
  end

  assign sum_o = sum_q;

  // R1: reset clears the result register
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (sum_q == '0));

  // R3: congruence with the integer sum
  a_r3_congruent: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((int'(sum_q) % MODV) ==
              ((int'($past(a_i)) + int'($past(b_i))) % MODV)));

  // R4: exact end-around value
  a_r4_exact: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (int'(sum_q) ==
      (((int'($past(a_i)) + int'($past(b_i))) > MODV) ?
        (int'($past(a_i)) + int'($past(b_i)) - MODV) :
        (int'($past(a_i)) + int'($past(b_i))))));

  // R5: all-propagate ring gives the all-ones zero
  a_r5_ring_zero: assert property (@(posedge clk) disable iff (rst)
    (&(a_i ^ b_i)) |=> (&sum_q));

  // R6: a top-bit-only generate wraps into bit 0
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    ((a_i & b_i) == {1'b1, {(W-1){1'b0}}} && (a_i ^ b_i) == '0) |=>
      (sum_q == {{(W-1){1'b0}}, 1'b1}));
endmodule

// File: tb/sim_eac_mod_adder.sv
module sim_eac_mod_adder;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int MODV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] sum_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  eac_mod_adder #(.W(W)) u0 (.clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sum_o(sum_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expect_sum(input int a, input int b);
    int s;
    s = a + b;
    return (s > MODV) ? s - MODV : s;
  endfunction

  task automatic apply(input int a, input int b);
    @(negedge clk);
    a_i = a[W-1:0];
    b_i = b[W-1:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    a_i = 8'hA5; b_i = 8'h3C;
    @(posedge clk); @(negedge clk);
    check("R1", int'(sum_o), 0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    apply(8'h12, 8'h34);
    check("R2", int'(sum_o), 8'h46);
    a_i = 8'h01; b_i = 8'h01;
    #1;
    check("R2", int'(sum_o), 8'h46);
  endtask

  task automatic t_exhaustive;
    for (int a = 0; a <= MODV; a++) begin
      for (int b = 0; b <= MODV; b++) begin
        apply(a, b);
        check("R4", int'(sum_o), expect_sum(a, b));
        if (int'(sum_o) % MODV != (a + b) % MODV)
          check("R3", int'(sum_o) % MODV, (a + b) % MODV);
      end
    end
  endtask

  task automatic t_zero_forms;
    apply(8'hFF, 8'h00); check("R5", int'(sum_o), 8'hFF);
    apply(8'h5A, 8'hA5); check("R5", int'(sum_o), 8'hFF);
    apply(8'h00, 8'h00); check("R5", int'(sum_o), 8'h00);
    apply(8'hFF, 8'hFF); check("R5", int'(sum_o), 8'hFF);
  endtask

  task automatic t_ring_carry;
    apply(8'h80, 8'h80); check("R6", int'(sum_o), 8'h01);
    apply(8'hFF, 8'h01); check("R6", int'(sum_o), 8'h01);
    apply(8'hC0, 8'h41); check("R6", int'(sum_o), 8'h02);
    apply(8'hFE, 8'h02); check("R6", int'(sum_o), 8'h01);
  endtask

  task automatic t_commute;
    int r1;
    apply(8'h9D, 8'h77); r1 = int'(sum_o);
    apply(8'h77, 8'h9D);
    check("R7", int'(sum_o), r1);
    check("R7", int'(sum_o), expect_sum(8'h9D, 8'h77));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset;
    t_latency;
    t_zero_forms;
    t_ring_carry;
    t_commute;
    t_exhaustive;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule